// File: doc/BRIEF.md
# Trace Port Test Pattern Generator

This block drives a 16-bit parallel trace data bus with known diagnostic patterns, so that an external capture tool can check the integrity of every data line. There are four pattern families: a single 1 walking across the bus, a single 0 walking across the bus, the alternating pair 0xAAAA/0x5555, and the alternating pair 0xFFFF/0x0000. A companion control line is high in every cycle in which the bus carries a pattern.

Software configures the block with a single write-only 32-bit control word. In continuous mode, one chosen family repeats until a new word is written. In timed mode, every chosen family plays once in a fixed order. Each family is held for a programmed number of trace clock cycles, and the block then returns to idle. Words that do not describe a legal setup are discarded. A word with neither mode bit set stops the generator.

Top module: `trace_pattern_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no write yet taken, the data bus is 0x0000 and the control line is low. An asynchronous reset asserted mid-run clears both at once.
- R2: Control bit 13 chooses the walking-ones family. It starts at 0x0001 and rotates left by one bit each cycle, so 0x8000 is followed by 0x0001.
- R3: Control bit 12 chooses the walking-zeros family. It starts at 0xFFFE and rotates left by one bit each cycle.
- R4: Control bit 11 chooses the family 0xAAAA, 0x5555, 0xAAAA, and so on. Control bit 10 chooses the family 0xFFFF, 0x0000, 0xFFFF, and so on. Each family starts on its first value.
- R5: A word with bit 8 set, bit 9 clear and exactly one of bits 13..10 set starts continuous mode. The first pattern value appears in the cycle after the clock edge that takes the write, and the family then repeats without end.
- R6: A word with bit 9 set, bit 8 clear and at least one of bits 13..10 set starts timed mode. The chosen families play in the order walking-ones, walking-zeros, AA/55, FF/00, and unchosen families are skipped. Each family lasts N cycles, where N is bits 7..0 (0 to 255). The block goes idle after the last family.
- R7: A timed-mode word with N = 0 produces no pattern, and the block is idle from the next cycle.
- R8: A word with both bit 8 and bit 9 set, a continuous word with zero or several family bits, or a timed word with no family bit is discarded. The sequence in progress, or the idle state, continues exactly as if no write had occurred.
- R9: A word with bits 9 and 8 both clear stops any sequence. The bus reads 0x0000 and the control line is low from the next cycle.
- R10: Bits 31..14 of the control word have no effect.
- R11: The control line is high exactly in the cycles in which a pattern is driven. Whenever it is low, the data bus is 0x0000.
- R12: A legal write taken while a sequence runs abandons that sequence and starts the new setup from its first value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Trace clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en_i | input | 1 | Control word write strobe, one cycle per write |
| wr_data_i | input | 32 | Control word |
| trc_data_o | output | 16 | Trace data bus carrying the pattern |
| trc_ctl_o | output | 1 | High while a pattern is being driven |

## Verification
The outputs come straight from the state registers, so a wrong internal state shows on the bus in the very next cycle. A pattern register that misses an advance shows up as a repeated or skipped value. A duration counter that is off by one makes a family one cycle too long or too short, and this moves every later family. A fault in the selection order puts the wrong family at a segment boundary. The bench compares every cycle of each run against a model built from the requirements. A single wrong value therefore fails on the cycle it appears, and the long 255-cycle run catches counter faults that only show near the top of the count.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int NPAT      = 4;
  localparam int PIDX_W    = $clog2(NPAT);
  localparam int CW_W      = 32;
  localparam int FAM_HI    = 13;  // walking-ones; lower bits follow the play order
  localparam int MODE_TIME = 9;
  localparam int MODE_CONT = 8;

  typedef enum logic [PIDX_W-1:0] {
    PAT_W1   = 2'd0,
    PAT_W0   = 2'd1,
    PAT_AA55 = 2'd2,
    PAT_FF00 = 2'd3
  } pat_e;

  typedef enum logic [1:0] {
    CMD_STOP,
    CMD_CONT,
    CMD_TIMED,
    CMD_BAD
  } cmd_e;
endpackage

// File: rtl/tpg_decode.sv
module tpg_decode
  import tpg_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic [CW_W-1:0]  word_i,
  output cmd_e             cmd_o,
  output logic [NPAT-1:0]  mask_o,
  output logic [DUR_W-1:0] dur_o
);
  logic is_timed, is_cont;
  logic [$clog2(NPAT+1)-1:0] n_sel;

  // mask index 0 is the first family played
  for (genvar g = 0; g < NPAT; g++) begin : g_mask
    assign mask_o[g] = word_i[FAM_HI-g];
  end

  assign dur_o    = word_i[DUR_W-1:0];
  assign is_timed = word_i[MODE_TIME];
  assign is_cont  = word_i[MODE_CONT];
  assign n_sel    = $countones(mask_o);

  always_comb begin
    if (is_timed && is_cont)  cmd_o = CMD_BAD;
    else if (is_cont)         cmd_o = (n_sel == 1) ? CMD_CONT : CMD_BAD;
    else if (is_timed)        cmd_o = (n_sel != 0) ? CMD_TIMED : CMD_BAD;
    else                      cmd_o = CMD_STOP;
  end
endmodule

// File: rtl/tpg_sequencer.sv
module tpg_sequencer
  import tpg_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  cmd_e             cmd_i,
  input  logic [NPAT-1:0]  mask_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             act_o,
  output pat_e             pat_o,
  output logic             load_o,
  output logic             step_o,
  output logic             clr_o
);
  logic             act_q, act_d;
  logic             timed_q, timed_d;
  pat_e             cur_q, cur_d;
  logic [NPAT-1:0]  mask_q, mask_d;
  logic [DUR_W-1:0] dur_q, dur_d;
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic [PIDX_W:0]  first_w, next_w;

  function automatic logic [PIDX_W:0] first_sel(input logic [NPAT-1:0] m, input int from);
    logic [PIDX_W:0] r;
    r = '0;
    for (int i = 0; i < NPAT; i++) begin
      if (!r[PIDX_W] && i >= from && m[i]) r = {1'b1, PIDX_W'(i)};
    end
    return r;
  endfunction

  assign first_w = first_sel(mask_i, 0);
  assign next_w  = first_sel(mask_q, int'(cur_q) + 1);

  always_comb begin
    act_d   = act_q;
    timed_d = timed_q;
    cur_d   = cur_q;
    mask_d  = mask_q;
    dur_d   = dur_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    clr_o   = 1'b0;
    if (wr_en_i && cmd_i != CMD_BAD) begin
      mask_d  = mask_i;
      dur_d   = dur_i;
      timed_d = (cmd_i == CMD_TIMED);
      cur_d   = pat_e'(first_w[PIDX_W-1:0]);
      cnt_d   = dur_i - 1'b1;
      if (cmd_i == CMD_STOP || (cmd_i == CMD_TIMED && dur_i == '0)) begin
        act_d = 1'b0;
        clr_o = 1'b1;
      end else begin
        act_d  = 1'b1;
        load_o = 1'b1;
      end
    end else if (act_q) begin
      if (!timed_q) begin
        step_o = 1'b1;
      end else if (cnt_q == '0) begin
        if (next_w[PIDX_W]) begin
          cur_d  = pat_e'(next_w[PIDX_W-1:0]);
          cnt_d  = dur_q - 1'b1;
          load_o = 1'b1;
        end else begin
          act_d = 1'b0;
          clr_o = 1'b1;
        end
      end else begin
        cnt_d  = cnt_q - 1'b1;
        step_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      timed_q <= 1'b0;
      cur_q   <= PAT_W1;
      mask_q  <= '0;
      dur_q   <= '0;
      cnt_q   <= '0;
    end else begin
      act_q   <= act_d;
      timed_q <= timed_d;
      cur_q   <= cur_d;
      mask_q  <= mask_d;
      dur_q   <= dur_d;
      cnt_q   <= cnt_d;
    end
  end

  assign act_o = act_q;
  assign pat_o = (load_o) ? cur_d : cur_q;

  // R6: within a family the remaining count stays below the programmed duration
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_n)
    (act_q && timed_q) |-> (cnt_q < dur_q));
  // R6: at the end of a segment the next family lies later in the play order, or the run ends
  a_r6_forward: assert property (@(posedge clk_i) disable iff (!rst_n)
    (act_q && timed_q && !wr_en_i && cnt_q == '0) |=> (!act_q || cur_q > $past(cur_q)));
  // R5: continuous mode keeps its family while no write arrives
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (act_q && !timed_q && !wr_en_i) |=> (act_q && $stable(cur_q)));
  // R8: a discarded word does not wake an idle generator
  a_r8_bad_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!act_q && wr_en_i && cmd_i == CMD_BAD) |=> !act_q);
endmodule

// File: rtl/tpg_pattern_core.sv
module tpg_pattern_core
  import tpg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  pat_e              pat_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] SEED_W1 = DATA_W'(1);
  localparam logic [DATA_W-1:0] SEED_W0 = ~SEED_W1;
  localparam logic [DATA_W-1:0] SEED_AA = {(DATA_W/2){2'b10}};
  localparam logic [DATA_W-1:0] SEED_FF = '1;

  logic [DATA_W-1:0] data_q, data_d;
  logic              en;

  function automatic logic [DATA_W-1:0] seed_of(input pat_e p);
    case (p)
      PAT_W1:   return SEED_W1;
      PAT_W0:   return SEED_W0;
      PAT_AA55: return SEED_AA;
      default:  return SEED_FF;
    endcase
  endfunction

  assign en = clr_i | load_i | step_i;

  always_comb begin
    if (clr_i)       data_d = '0;
    else if (load_i) data_d = seed_of(pat_i);
    else if (pat_i == PAT_W1 || pat_i == PAT_W0)
                     data_d = {data_q[DATA_W-2:0], data_q[DATA_W-1]};
    else             data_d = ~data_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)  data_q <= '0;
    else if (en) data_q <= data_d;
  end

  assign data_o = data_q;

  // R4: the two alternating families invert the whole bus on every advance
  a_r4_alternate: assert property (@(posedge clk_i) disable iff (!rst_n)
    (step_i && !clr_i && !load_i && (pat_i == PAT_AA55 || pat_i == PAT_FF00))
      |=> (data_q == ~$past(data_q)));
endmodule

// File: rtl/trace_pattern_gen.sv
module trace_pattern_gen
  import tpg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DUR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CW_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0] trc_data_o,
  output logic              trc_ctl_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  cmd_e             cmd;
  logic [NPAT-1:0]  mask;
  logic [DUR_W-1:0] dur;
  pat_e             pat;
  logic             act, load, step, clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  tpg_decode #(.DUR_W(DUR_W)) u_dec (
    .word_i (wr_data_i),
    .cmd_o  (cmd),
    .mask_o (mask),
    .dur_o  (dur)
  );

  tpg_sequencer #(.DUR_W(DUR_W)) u_seq (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .cmd_i   (cmd),
    .mask_i  (mask),
    .dur_i   (dur),
    .act_o   (act),
    .pat_o   (pat),
    .load_o  (load),
    .step_o  (step),
    .clr_o   (clr)
  );

  tpg_pattern_core #(.DATA_W(DATA_W)) u_core (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .pat_i  (pat),
    .load_i (load),
    .step_i (step),
    .clr_i  (clr),
    .data_o (trc_data_o)
  );

  assign trc_ctl_o = act;

  // R11: an idle generator drives an all-zero bus
  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    !trc_ctl_o |-> (trc_data_o == '0));
  // R2: walking-ones always carries exactly one high bit
  a_r2_one_hot: assert property (@(posedge clk_i) disable iff (!rst_n)
    (trc_ctl_o && pat == PAT_W1 && !load) |-> ($countones(trc_data_o) == 1));
  // R3: walking-zeros always carries exactly one low bit
  a_r3_one_cold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (trc_ctl_o && pat == PAT_W0 && !load) |-> ($countones(trc_data_o) == DATA_W-1));
endmodule

// File: tb/sim_trace_pattern_gen.sv
`timescale 1ns/1ps
module sim_trace_pattern_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [15:0] trc_data_o;
  logic        trc_ctl_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  trace_pattern_gen u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .trc_data_o(trc_data_o),
    .trc_ctl_o (trc_ctl_o)
  );

  localparam int NV = 10;
  localparam logic [31:0] VEC_W [NV] = '{
    32'h0000_2100, // R2 R5 continuous walking ones
    32'h0000_1100, // R3 continuous walking zeros
    32'h0000_0900, // R4 continuous AA/55
    32'h0000_0500, // R4 continuous FF/00
    32'h0000_3E03, // R6 timed, all four, 3 cycles each
    32'h0000_2A05, // R6 timed, walking ones and AA/55 only
    32'h0000_0601, // R6 timed, FF/00 for a single cycle
    32'h0000_3E00, // R7 timed, zero duration
    32'hFFFC_0900, // R10 reserved bits set
    32'h0000_3EFF  // R6 timed, 255 cycles each
  };
  localparam int VEC_N [NV] = '{40, 36, 8, 8, 16, 14, 4, 4, 8, 1024};

  function automatic string vec_tag(input int v);
    case (v)
      0: return "R2 R5 R11";
      1: return "R3 R5";
      2, 3: return "R4 R5";
      4, 5, 6, 9: return "R6 R11 R12";
      7: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] pv(input int p, input int i);
    case (p)
      0: return 16'(1) << (i % 16);
      1: return ~(16'(1) << (i % 16));
      2: return (i % 2 == 1) ? 16'h5555 : 16'hAAAA;
      default: return (i % 2 == 1) ? 16'h0000 : 16'hFFFF;
    endcase
  endfunction

  // {ctl, data} expected k cycles after the first pattern cycle of word w
  function automatic logic [16:0] model(input logic [31:0] w, input int k);
    int dur, seg, n;
    dur = int'(w[7:0]);
    if (w[8]) begin
      for (int p = 0; p < 4; p++) if (w[13-p]) return {1'b1, pv(p, k)};
      return '0;
    end
    if (!w[9] || dur == 0) return '0;
    seg = k / dur;
    n = 0;
    for (int p = 0; p < 4; p++) begin
      if (w[13-p]) begin
        if (n == seg) return {1'b1, pv(p, k % dur)};
        n++;
      end
    end
    return '0;
  endfunction

  task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got ctl=%0b data=%h, expected ctl=%0b data=%h",
               tag, got[16], got[15:0], exp[16], exp[15:0]);
    end
  endtask

  // leaves the caller at the negedge where the first pattern value is visible
  task automatic write_word(input logic [31:0] w);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = w;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic run_model(input string tag, input logic [31:0] w, input int n);
    write_word(w);
    for (int k = 0; k < n; k++) begin
      check(tag, {trc_ctl_o, trc_data_o}, model(w, k));
      @(negedge clk_i);
    end
  endtask

  initial begin
    // R1: reset state while asserted and after release
    repeat (3) @(negedge clk_i);
    check("R1 in reset", {trc_ctl_o, trc_data_o}, 17'h0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 after release", {trc_ctl_o, trc_data_o}, 17'h0);

    // table of control words walked by one loop
    for (int v = 0; v < NV; v++) run_model(vec_tag(v), VEC_W[v], VEC_N[v]);

    // R8: discarded words while continuous walking ones runs
    begin
      logic [31:0] bad [4] = '{32'h0000_2300, 32'h0000_3100, 32'h0000_0100, 32'h0000_0200};
      int k;
      write_word(32'h0000_2100);
      k = 0;
      for (int b = 0; b < 4; b++) begin
        check("R8 before bad word", {trc_ctl_o, trc_data_o}, model(32'h0000_2100, k));
        wr_en_i = 1'b1;
        wr_data_i = bad[b];
        @(negedge clk_i);
        wr_en_i = 1'b0;
        wr_data_i = '0;
        k++;
        check("R8 after bad word", {trc_ctl_o, trc_data_o}, model(32'h0000_2100, k));
        @(negedge clk_i);
        k++;
      end
    end

    // R9: stop word ends continuous AA/55
    write_word(32'h0000_0900);
    @(negedge clk_i);
    write_word(32'h0000_0000);
    check("R9 stop", {trc_ctl_o, trc_data_o}, 17'h0);

    // R8: discarded word while idle leaves it idle
    write_word(32'h0000_3100);
    check("R8 idle stays idle", {trc_ctl_o, trc_data_o}, 17'h0);
    @(negedge clk_i);
    check("R8 idle stays idle later", {trc_ctl_o, trc_data_o}, 17'h0);

    // R12: new legal word mid-timed-run restarts at its first value
    write_word(32'h0000_3E04);
    repeat (6) @(negedge clk_i);
    check("R12 timed mid-run", {trc_ctl_o, trc_data_o}, {1'b1, 16'hFFFB});
    write_word(32'h0000_0500);
    check("R12 restart first value", {trc_ctl_o, trc_data_o}, {1'b1, 16'hFFFF});
    @(negedge clk_i);
    check("R12 restart second value", {trc_ctl_o, trc_data_o}, {1'b1, 16'h0000});

    // R1: asynchronous reset mid-run
    write_word(32'h0000_2100);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", {trc_ctl_o, trc_data_o}, 17'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 after second release", {trc_ctl_o, trc_data_o}, 17'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got still running, expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule